// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Float Converter

This block turns one signed fixed-point word into an IEEE-754 single-precision word. The input is 64 bits wide in two's complement, with 40 bits below the binary point and 24 above it. A caller presents the word together with a one-cycle start request. The block raises busy and works through three phases. The first phase captures the sign and the magnitude. The second finds the leading one of the magnitude by halving a search window over six cycles. The third packs the sign, a biased exponent and a truncated 23-bit fraction into the result. The result appears with a one-cycle done strobe.

Only one conversion runs at a time. A start request made while busy is high is dropped. The output never carries NaN, infinity or denormal encodings. No rounding is done, and bits below the kept fraction are simply discarded. The widths, the fraction position and the exponent bias are parameters, and elaboration checks that they agree with one another.

Top module: `fxp_to_sfloat`

## Requirements
- R1: For a positive nonzero input, bit 31 of the result is 0. Bits 30:23 hold (index of the highest set bit) − 40 + 127. Bits 22:0 hold the 23 input bits just below that highest set bit, in order, so 9.5 (input 0x0000_0980_0000_0000) gives 0x4118_0000.
- R2: An input with bit 63 set is read as two's complement. The result has bit 31 set, and bits 30:0 are encoded from the negated magnitude as in R1. -9.5 gives 0xC118_0000, and 0x8000_0000_0000_0000 gives 0xCB00_0000.
- R3: An all-zero input gives a result of all zeros (+0.0).
- R4: When the highest set bit has an index below 23, the fraction field is filled from the top with the bits that exist below it, and the rest is zero padding. Input 1 gives 0x2B80_0000, and input 5 gives 0x2CA0_0000.
- R5: Bits below the 23 kept fraction bits are dropped with no rounding. 0x7FFF_FFFF_FFFF_FFFF gives 0x4AFF_FFFF.
- R6: A start request taken on a clock edge with busy low sets busy after that edge. done_o rises after the ninth edge counted from and including the accepting edge, and busy falls after that same edge.
- R7: done_o is high for exactly one cycle per conversion. flt_o keeps its value until the next done pulse.
- R8: A start request while busy is high has no effect. The running conversion returns the result for its own input, gives a single done pulse, and is not followed by a second conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to convert fxp_i, taken only while busy_o is low |
| fxp_i | input | 64 | Signed fixed-point word, 40 fraction bits |
| busy_o | output | 1 | High while a conversion is in progress |
| done_o | output | 1 | One-cycle strobe marking a new result on flt_o |
| flt_o | output | 32 | Single-precision result: sign, 8-bit exponent, 23-bit fraction |

## Verification
The bench sends several kinds of input, and each kind exposes a different error. Directed values include 9.5 and its negation, the most negative word, the largest positive word, zero, and small integers whose leading one sits below bit 23. Together they separate a wrong exponent offset, a wrong sign or negation path, a missing zero path, wrong padding of short fractions, and rounding in place of truncation. Random words are shifted right by a random amount and randomly negated. This moves the leading one across all 64 positions, so every branch of the halving search is taken in both directions. Each result is compared with a reference function in the bench. One directed case also sends a second start request in the middle of a conversion, to show that the request is dropped.

// File: rtl/fx2f_pkg.sv
package fx2f_pkg;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_INIT   = 2'd1,
      ST_SEARCH = 2'd2,
      ST_ENCODE = 2'd3
   } cvt_state_e;

endpackage

// File: rtl/fx2f_magnitude.sv
module fx2f_magnitude #(
   parameter int FXP_W = 64
) (
   input  logic [FXP_W-1:0] raw_i,
   output logic             neg_o,
   output logic [FXP_W-1:0] mag_o
);

   always_comb begin
      neg_o = raw_i[FXP_W-1];
      if (neg_o) begin
         mag_o = ~raw_i + FXP_W'(1);
      end else begin
         mag_o = raw_i;
      end
   end

endmodule

// File: rtl/fx2f_msb_search.sv
module fx2f_msb_search #(
   parameter int FXP_W = 64,
   parameter int POS_W = $clog2(FXP_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic             en_i,
   input  logic [FXP_W-1:0] mag_i,
   output logic [POS_W-1:0] pos_o,
   output logic             last_o
);

   localparam int STEPS  = POS_W;
   localparam int STEP_W = (STEPS > 1) ? $clog2(STEPS) : 1;

   logic [FXP_W-1:0]  win_q;
   logic [POS_W-1:0]  pos_q;
   logic [STEP_W-1:0] step_q;
   logic [POS_W-1:0]  half;
   logic [FXP_W-1:0]  upper;
   logic [FXP_W-1:0]  lower;
   logic              hit;

   always_comb begin
      half  = POS_W'((FXP_W / 2) >> step_q);
      upper = win_q >> half;
      lower = win_q & ~({FXP_W{1'b1}} << half);
      hit   = |upper;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q  <= '0;
         pos_q  <= '0;
         step_q <= '0;
      end else if (load_i) begin
         win_q  <= mag_i;
         pos_q  <= '0;
         step_q <= '0;
      end else if (en_i) begin
         if (hit) begin
            win_q <= upper;
            pos_q <= pos_q + half;
         end else begin
            win_q <= lower;
         end
         step_q <= step_q + STEP_W'(1);
      end
   end

   assign pos_o  = pos_q;
   assign last_o = en_i && (step_q == STEP_W'(STEPS - 1));

   // R1
   search_keeps_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && (win_q != '0)) |=> (win_q != '0));

   // R1
   search_converges_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |=> (win_q <= FXP_W'(1)));

   // R6
   step_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (step_q < STEP_W'(STEPS)));

endmodule

// File: rtl/fx2f_pack.sv
module fx2f_pack #(
   parameter int FXP_W  = 64,
   parameter int FRAC_W = 40,
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   parameter int BIAS   = 127,
   parameter int POS_W  = $clog2(FXP_W)
) (
   input  logic                   sign_i,
   input  logic [FXP_W-1:0]       mag_i,
   input  logic [POS_W-1:0]       pos_i,
   output logic [EXP_W+MAN_W:0]   word_o
);

   localparam int EXP_OFS = BIAS - FRAC_W;

   logic [POS_W-1:0] shamt;
   logic [FXP_W-1:0] norm;
   logic [MAN_W-1:0] frac;
   logic [EXP_W-1:0] expo;
   int               exp_sum;

   always_comb begin
      shamt   = POS_W'(FXP_W - 1) - pos_i;
      norm    = mag_i << shamt;
      frac    = norm[FXP_W-2 -: MAN_W];
      exp_sum = int'(pos_i) + EXP_OFS;
      expo    = exp_sum[EXP_W-1:0];
      if (mag_i == '0) begin
         word_o = '0;
      end else begin
         word_o = {sign_i, expo, frac};
      end
   end

endmodule

// File: rtl/fxp_to_sfloat.sv
module fxp_to_sfloat #(
   parameter int FXP_W  = 64,
   parameter int FRAC_W = 40,
   parameter int EXP_W  = 8,
   parameter int MAN_W  = 23,
   parameter int BIAS   = 127
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic [FXP_W-1:0]     fxp_i,
   output logic                 busy_o,
   output logic                 done_o,
   output logic [EXP_W+MAN_W:0] flt_o
);
   import fx2f_pkg::*;

   localparam int POS_W = $clog2(FXP_W);
   localparam int STEPS = POS_W;
   localparam int FLT_W = 1 + EXP_W + MAN_W;
   localparam int LAT   = STEPS + 3;
   localparam int LAT_W = $clog2(LAT + 1);

   generate
      if ((FXP_W & (FXP_W - 1)) != 0 || FXP_W < 4) begin : g_bad_width
         $error("fxp_to_sfloat: FXP_W must be a power of two of at least 4");
      end
      if (FRAC_W >= FXP_W || FRAC_W < 0) begin : g_bad_frac
         $error("fxp_to_sfloat: FRAC_W must lie inside the input word");
      end
      if (MAN_W > FXP_W - 1) begin : g_bad_man
         $error("fxp_to_sfloat: MAN_W exceeds the bits below the leading one");
      end
      if (BIAS - FRAC_W < 1 || (FXP_W - 1 - FRAC_W + BIAS) > (2 ** EXP_W) - 2) begin : g_bad_exp
         $error("fxp_to_sfloat: exponent range does not fit EXP_W");
      end
   endgenerate

   cvt_state_e       state_q;
   logic [FXP_W-1:0] raw_q;
   logic             sign_q;
   logic [FXP_W-1:0] mag_q;
   logic [FLT_W-1:0] res_q;
   logic             done_q;

   logic             neg_c;
   logic [FXP_W-1:0] mag_c;
   logic [POS_W-1:0] pos_c;
   logic             last_c;
   logic [FLT_W-1:0] word_c;
   logic             accept;

   assign accept = start_i && (state_q == ST_IDLE);

   fx2f_magnitude #(
      .FXP_W (FXP_W)
   ) u_mag (
      .raw_i (raw_q),
      .neg_o (neg_c),
      .mag_o (mag_c)
   );

   fx2f_msb_search #(
      .FXP_W (FXP_W),
      .POS_W (POS_W)
   ) u_search (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (state_q == ST_INIT),
      .en_i   (state_q == ST_SEARCH),
      .mag_i  (mag_c),
      .pos_o  (pos_c),
      .last_o (last_c)
   );

   fx2f_pack #(
      .FXP_W  (FXP_W),
      .FRAC_W (FRAC_W),
      .EXP_W  (EXP_W),
      .MAN_W  (MAN_W),
      .BIAS   (BIAS),
      .POS_W  (POS_W)
   ) u_pack (
      .sign_i (sign_q),
      .mag_i  (mag_q),
      .pos_i  (pos_c),
      .word_o (word_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         raw_q   <= '0;
         sign_q  <= 1'b0;
         mag_q   <= '0;
         res_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  raw_q   <= fxp_i;
                  state_q <= ST_INIT;
               end
            end
            ST_INIT: begin
               sign_q  <= neg_c;
               mag_q   <= mag_c;
               state_q <= ST_SEARCH;
            end
            ST_SEARCH: begin
               if (last_c) begin
                  state_q <= ST_ENCODE;
               end
            end
            ST_ENCODE: begin
               res_q   <= word_c;
               done_q  <= 1'b1;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state_q != ST_IDLE);
   assign done_o = done_q;
   assign flt_o  = res_q;

   // cycles since the accepting edge, used only by the checks below
   logic [LAT_W-1:0] lat_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
      end else if (accept) begin
         lat_q <= LAT_W'(1);
      end else if (busy_o) begin
         lat_q <= lat_q + LAT_W'(1);
      end
   end

   // R6
   start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   // R6
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (lat_q == LAT_W'(LAT)) && !busy_o);

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(flt_o));

   // R8
   busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !done_o) |=> (lat_q == $past(lat_q) + LAT_W'(1)));

   // R3
   zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (flt_o[FLT_W-2 -: EXP_W] == '0)) |-> (flt_o == '0));

endmodule

// File: tb/fxp_to_sfloat_test.sv
`timescale 1ns/1ps
module fxp_to_sfloat_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [63:0] din = '0;
   logic        busy;
   logic        done;
   logic [31:0] flt;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;

   always #2 clk = ~clk;

   fxp_to_sfloat uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .fxp_i   (din),
      .busy_o  (busy),
      .done_o  (done),
      .flt_o   (flt)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         n_fail++;
         $display("FAIL R6 watchdog: act=still running exp=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] ref_conv(input logic [63:0] x);
      logic [63:0] m;
      logic [63:0] n;
      logic [7:0]  e;
      int          p;
      m = x[63] ? (~x + 64'd1) : x;
      p = -1;
      for (int i = 0; i < 64; i++) if (m[i]) p = i;
      if (p < 0) return 32'd0;
      n = m << (63 - p);
      e = 8'(p - 40 + 127);
      return {x[63], e, n[62:40]};
   endfunction

   task automatic convert(input logic [63:0] x, input logic [31:0] want,
                          input string req, input bit poke);
      int first_done = -1;
      int pulses     = 0;
      bit busy_bad   = 1'b0;
      logic [31:0] got;
      @(negedge clk);
      start = 1'b1;
      din   = x;
      for (int k = 1; k <= 10; k++) begin
         @(negedge clk);
         if (k == 1) begin start = 1'b0; din = '0; end
         if (poke && k == 3) begin start = 1'b1; din = ~x; end
         if (poke && k == 4) start = 1'b0;
         if (done) begin
            pulses++;
            if (first_done < 0) first_done = k;
         end
         if (k <= 8 && !busy) busy_bad = 1'b1;
         if (k == 9) begin
            got = flt;
            if (busy) busy_bad = 1'b1;
         end
      end
      chk(got == want, req, 64'(got), 64'(want));
      chk(first_done == 9 && !busy_bad, "R6 latency",
          64'(first_done), 64'd9);
      chk(pulses == 1 && flt == got, "R7 pulse/hold",
          64'(pulses), 64'd1);
      if (poke) chk(!busy && !done && flt == want, "R8 restart",
                    {31'd0, busy, flt}, {32'd0, want});
   endtask

   initial begin
      logic [63:0] x;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!busy && !done && flt == 32'd0, "R7 reset state",
          {31'd0, busy, flt}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      convert(64'h0000_0980_0000_0000, 32'h4118_0000, "R1 9.5", 1'b0);
      convert(-64'h0000_0980_0000_0000, 32'hC118_0000, "R2 -9.5", 1'b0);
      convert(64'h8000_0000_0000_0000, 32'hCB00_0000, "R2 most negative", 1'b0);
      convert(64'd0, 32'd0, "R3 zero", 1'b0);
      convert(64'd1, 32'h2B80_0000, "R4 lsb only", 1'b0);
      convert(64'd5, 32'h2CA0_0000, "R4 short fraction", 1'b0);
      convert(64'h7FFF_FFFF_FFFF_FFFF, 32'h4AFF_FFFF, "R5 truncation", 1'b0);
      convert(64'h0000_0100_0000_0000, 32'h3F80_0000, "R1 one", 1'b0);
      convert(64'h0000_0980_0000_0000, 32'h4118_0000, "R8 busy start", 1'b1);
      convert(64'hFFFF_FFFF_FFFF_FFFF, 32'hAB80_0000, "R2 minus lsb", 1'b0);

      for (int t = 0; t < 300; t++) begin
         x = {$urandom(), $urandom()};
         x = x >> $urandom_range(63, 0);
         if ($urandom_range(1, 0) == 1) x = -x;
         convert(x, ref_conv(x), x[63] ? "R2 random" : "R1 random", (t % 37) == 0);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule